// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-side register set of a legacy byte-wide printer port. A host reaches three registers (the data latch, the port status and the port control) through single-cycle read and write strobes, with the low three address bits selecting the register. No real printer lines are driven. Instead the block emulates the printer's side of the handshake. A rising strobe written through the control register hands the latched data byte to a byte-output stream. Successive status reads then step the acknowledge and busy bits the way a polling driver expects to see them.

A level interrupt output follows an internal pending flag. The flag is raised when strobe is asserted through the control register while interrupts are enabled, and any status read clears it. A separate input latch, loaded from an external byte port, supplies the value that data reads return when the control register selects the read direction.

Top module: `prnport_regs`

## Requirements
- R1: Only address bits 2:0 are decoded: 0 is data, 1 is status, 2 is control. Offsets 3 to 7 read as 0xFF and ignore writes. Read data appears on `rdData` in the cycle after `rdEn`. When `rdEn` and `wrEn` are both high, only the write is performed.
- R2: After reset, data reads return 0xFF, status reads 0xD9 and control reads 0xCC, and `irq` and `outValid` are 0.
- R3: A control write stores `wrData | 0xC0`, which later control reads return. Control bits: 5 direction (1 = read), 4 interrupt enable, 3 inverted select, 2 inverted init, 0 inverted strobe.
- R4: A control write with bit 2 = 0 loads status with 0xD8.
- R5: A control write with bits 3 and 2 both 1 and bit 0 = 1 clears status bit 7. If the stored control bit 0 was 0 before that write, `outValid` pulses for exactly one cycle, with `outByte` equal to the data latch.
- R6: A control write with bits 3 and 2 both 1 and bit 0 = 0 raises `irq` one cycle later if the stored control bit 4 is 1. If that bit is 0, the write leaves `irq` unchanged.
- R7: A status read clears `irq` in the cycle after the read.
- R8: Status bits: 7 inverted busy, 6 acknowledge, 4 online, 3 inverted error, 0 timeout. A status read returns the value held before the read. If status bit 7 and stored control bit 0 are both 0, the read then clears bit 6 when it was 1, and otherwise sets bits 7 and 6.
- R9: A data read returns the input latch when control bit 5 is 1, and the last byte written to offset 0 when it is 0.
- R10: `inLoad` loads `inData` into the input latch on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address; bits 2:0 decoded |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| inData | input | 8 | External byte for the input latch |
| inLoad | input | 1 | Loads the input latch |
| outValid | output | 1 | One-cycle pulse: byte emitted |
| outByte | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt |

## Verification
Every result is due one clock after the access that causes it. Read data, the `irq` change, the `outValid` pulse and the status-sequencer update all register on the same edge that samples the strobe. The bench drives each access on a falling edge and samples at the next falling edge, which falls half a cycle after that register edge. Each pulse check is paired with a check one cycle later, which shows the pulse has ended.

// File: rtl/prnport_pkg.sv
package prnport_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;

  localparam logic [BYTE_W-1:0] CTRL_FORCED = 8'hC0;
  localparam logic [BYTE_W-1:0] STAT_RESET  = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_IDLE   = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'hCC;
  localparam logic [BYTE_W-1:0] DATA_RESET  = 8'hFF;
  localparam logic [BYTE_W-1:0] READ_EMPTY  = 8'hFF;

  localparam int CB_DIR    = 5;
  localparam int CB_IRQEN  = 4;
  localparam int CB_SELN   = 3;
  localparam int CB_INITN  = 2;
  localparam int CB_STROBN = 0;
  localparam int SB_BUSYN  = 7;
  localparam int SB_ACK    = 6;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic loadIdle;
    logic clearBusy;
    logic emitByte;
    logic raiseIrq;
    logic ackClear;
    logic ackBusySet;
    logic rdData;
    logic rdStatus;
    logic rdCtrl;
    logic rdOther;
  } prnStrobe_t;
endpackage

// File: rtl/prnport_ctrl.sv
module prnport_ctrl
  import prnport_pkg::*;
(
  input  logic [2:0]  regSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        newStrobeN,
  input  logic        newSelectN,
  input  logic        newInitN,
  input  logic        curStrobeN,
  input  logic        curIrqEn,
  input  logic        stBusyN,
  input  logic        stAck,
  output prnStrobe_t  stb
);
  logic doWr;
  logic doRd;
  logic selData;
  logic selStat;
  logic selCtrl;
  logic handshakeArmed;

  assign doWr    = wrEn;
  assign doRd    = rdEn && !wrEn;
  assign selData = (regSel == OFS_DATA);
  assign selStat = (regSel == OFS_STATUS);
  assign selCtrl = (regSel == OFS_CTRL);
  assign handshakeArmed = !stBusyN && !curStrobeN;

  always_comb begin
    stb = '0;
    if (doWr) begin
      stb.wrData = selData;
      stb.wrCtrl = selCtrl;
      if (selCtrl) begin
        if (!newInitN) begin
          stb.loadIdle = 1'b1;
        end else if (newSelectN) begin
          if (newStrobeN) begin
            stb.clearBusy = 1'b1;
            stb.emitByte  = !curStrobeN;
          end else begin
            stb.raiseIrq = curIrqEn;
          end
        end
      end
    end
    if (doRd) begin
      stb.rdData   = selData;
      stb.rdStatus = selStat;
      stb.rdCtrl   = selCtrl;
      stb.rdOther  = !(selData || selStat || selCtrl);
      if (selStat && handshakeArmed) begin
        stb.ackClear   = stAck;
        stb.ackBusySet = !stAck;
      end
    end
  end
endmodule

// File: rtl/prnport_dp.sv
module prnport_dp
  import prnport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  prnStrobe_t        stb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLoad,
  output logic [BYTE_W-1:0] rdData,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              pendQ,
  output logic [BYTE_W-1:0] statQ,
  output logic [BYTE_W-1:0] ctrlQ
);
  logic [BYTE_W-1:0] latchOut;
  logic [BYTE_W-1:0] latchIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchOut <= DATA_RESET;
      latchIn  <= DATA_RESET;
      statQ    <= STAT_RESET;
      ctrlQ    <= CTRL_RESET;
      pendQ    <= 1'b0;
      outValid <= 1'b0;
      outByte  <= '0;
      rdData   <= '0;
    end else begin
      if (inLoad) latchIn <= inData;
      if (stb.wrData) latchOut <= wrData;
      if (stb.wrCtrl) ctrlQ <= wrData | CTRL_FORCED;

      if (stb.loadIdle) begin
        statQ <= STAT_IDLE;
      end else if (stb.clearBusy) begin
        statQ[SB_BUSYN] <= 1'b0;
      end else if (stb.ackClear) begin
        statQ[SB_ACK] <= 1'b0;
      end else if (stb.ackBusySet) begin
        statQ[SB_BUSYN] <= 1'b1;
        statQ[SB_ACK]   <= 1'b1;
      end

      if (stb.raiseIrq) begin
        pendQ <= 1'b1;
      end else if (stb.rdStatus) begin
        pendQ <= 1'b0;
      end

      outValid <= stb.emitByte;
      if (stb.emitByte) outByte <= latchOut;

      if (stb.rdData) begin
        rdData <= ctrlQ[CB_DIR] ? latchIn : latchOut;
      end else if (stb.rdStatus) begin
        rdData <= statQ;
      end else if (stb.rdCtrl) begin
        rdData <= ctrlQ;
      end else if (stb.rdOther) begin
        rdData <= READ_EMPTY;
      end
    end
  end
endmodule

// File: rtl/prnport_regs.sv
module prnport_regs
  import prnport_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        inData,
  input  logic              inLoad,
  output logic              outValid,
  output logic [7:0]        outByte,
  output logic              irq
);
  prnStrobe_t        stb;
  logic [BYTE_W-1:0] statQ;
  logic [BYTE_W-1:0] ctrlQ;
  logic              pendQ;

  prnport_ctrl u_ctrl (
    .regSel     (addr[2:0]),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .newStrobeN (wrData[CB_STROBN]),
    .newSelectN (wrData[CB_SELN]),
    .newInitN   (wrData[CB_INITN]),
    .curStrobeN (ctrlQ[CB_STROBN]),
    .curIrqEn   (ctrlQ[CB_IRQEN]),
    .stBusyN    (statQ[SB_BUSYN]),
    .stAck      (statQ[SB_ACK]),
    .stb        (stb)
  );

  prnport_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .inData   (inData),
    .inLoad   (inLoad),
    .rdData   (rdData),
    .outValid (outValid),
    .outByte  (outByte),
    .pendQ    (pendQ),
    .statQ    (statQ),
    .ctrlQ    (ctrlQ)
  );

  assign irq = pendQ;
endmodule

// File: rtl/prnport_chk.sv
module prnport_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              outValid,
  input logic              irq,
  input logic [7:0]        statQ,
  input logic [7:0]        ctrlQ
);
  // R1: unmapped offsets read as all ones
  a_r1_unmapped_ff: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr[2:0] > 3'd2) |=> (rdData == 8'hFF));

  // R3: control keeps the written byte with the two top bits forced
  a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[2:0] == 3'd2) |=> (ctrlQ == ($past(wrData) | 8'hC0)));

  // R4: init asserted resets status
  a_r4_init_idle: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[2:0] == 3'd2 && !wrData[2]) |=> (statQ == 8'hD8));

  // R5: emission lasts one cycle
  a_r5_emit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6: strobe low with interrupts enabled raises irq
  a_r6_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[2:0] == 3'd2 && wrData[3] && wrData[2] && !wrData[0] && ctrlQ[4])
    |=> irq);

  // R7: status read drops irq
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr[2:0] == 3'd1) |=> !irq);

  // R8: armed read with acknowledge set clears acknowledge
  a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr[2:0] == 3'd1 && !statQ[7] && !ctrlQ[0] && statQ[6])
    |=> !statQ[6]);
endmodule

bind prnport_regs prnport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .outValid (outValid),
  .irq      (irq),
  .statQ    (statQ),
  .ctrlQ    (ctrlQ)
);

// File: tb/test_prnport_regs.sv
`timescale 1ns/1ps
module test_prnport_regs;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic [7:0]    inData = '0;
  logic          inLoad = 1'b0;
  logic          outValid;
  logic [7:0]    outByte;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prnport_regs #(.ADDR_W(AW)) i_prnport_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .inData(inData), .inLoad(inLoad),
    .outValid(outValid), .outByte(outByte), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R2 irq", {7'd0, irq}, 8'h00);
    check("R2 outValid", {7'd0, outValid}, 8'h00);
    doRead(8'h00, v); check("R2 data", v, 8'hFF);
    doRead(8'h01, v); check("R2 status", v, 8'hD9);
    doRead(8'h02, v); check("R2 control", v, 8'hCC);
  endtask

  task automatic testDecode();
    logic [7:0] v;
    for (int k = 3; k < 8; k++) begin
      doRead(AW'(k), v); check("R1 unmapped", v, 8'hFF);
    end
    doRead(8'hF9, v); check("R1 alias status", v, 8'hD9);
    doWrite(8'h05, 8'h00);
    doRead(8'h02, v); check("R1 ignored write ctrl", v, 8'hCC);
    doRead(8'h01, v); check("R1 ignored write status", v, 8'hD9);
    // read and write together: write wins, read data unchanged
    doRead(8'h02, v);
    @(negedge clk);
    addr = 8'h00; wrData = 8'h33; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R1 collide no read", rdData, 8'hCC);
    doRead(8'h00, v); check("R1 collide write", v, 8'h33);
  endtask

  task automatic testHandshake();
    logic [7:0] v;
    doWrite(8'h00, 8'h5A);
    @(negedge clk);
    addr = 8'h02; wrData = 8'h0D; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R5 emit valid", {7'd0, outValid}, 8'h01);
    check("R5 emit byte", outByte, 8'h5A);
    @(negedge clk);
    check("R5 one cycle", {7'd0, outValid}, 8'h00);
    doRead(8'h01, v); check("R5 busy cleared", v, 8'h59);
    @(negedge clk);
    addr = 8'h02; wrData = 8'h0D; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R5 no repeat emit", {7'd0, outValid}, 8'h00);
    doRead(8'h02, v); check("R3 ctrl readback", v, 8'hCD);
    doWrite(8'h02, 8'h0C);
    check("R6 no irq when disabled", {7'd0, irq}, 8'h00);
    doRead(8'h01, v); check("R8 read 1", v, 8'h59);
    doRead(8'h01, v); check("R8 ack cleared", v, 8'h19);
    doRead(8'h01, v); check("R8 ack busy set", v, 8'hD9);
    doRead(8'h01, v); check("R8 idle hold", v, 8'hD9);
  endtask

  task automatic testIrq();
    logic [7:0] v;
    doWrite(8'h02, 8'h1C);
    check("R6 enable not yet stored", {7'd0, irq}, 8'h00);
    doWrite(8'h02, 8'h1C);
    check("R6 irq raised", {7'd0, irq}, 8'h01);
    doRead(8'h02, v); check("R6 irq held", {7'd0, irq}, 8'h01);
    doRead(8'h01, v);
    check("R7 irq cleared", {7'd0, irq}, 8'h00);
    doWrite(8'h02, 8'h18);
    check("R6 init low no irq", {7'd0, irq}, 8'h00);
    doRead(8'h01, v); check("R4 idle status", v, 8'hD8);
    doRead(8'h02, v); check("R3 top bits forced", v, 8'hD8);
  endtask

  task automatic testDirection();
    logic [7:0] v;
    @(negedge clk);
    inData = 8'hA5; inLoad = 1'b1;
    @(negedge clk);
    inLoad = 1'b0; inData = 8'h00;
    doWrite(8'h00, 8'h3C);
    doRead(8'h00, v); check("R9 write direction", v, 8'h3C);
    doWrite(8'h02, 8'h2C);
    doRead(8'h00, v); check("R10 input latch", v, 8'hA5);
    doRead(8'h02, v); check("R9 dir stored", v, 8'hEC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDecode();
    testHandshake();
    testIrq();
    testDirection();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule